// File: doc/BRIEF.md
# Byte staging FIFO with watermark-based data request

This block holds up to eight bytes between a host that reads and writes a data port and a bus engine that sends and receives bytes on a serial bus. It keeps a fill count, raises a high-water flag and a low-water flag against two programmable marks, and combines those flags with the residual byte counts to tell the host when to move more data. The residual counts, and whether a command is in progress, come from outside the block.

The host side checks each access against the active command. A write is only meaningful during a write command, and a read only during a read command; anything else is flagged as an invalid command and moves no data. Writing a full FIFO or reading an empty one moves no data either, and flags an overrun unless the pacing-allow input is high. Each accepted host access, and each command start pulse, leaves one service request pending toward the bus. During a write command that request sends the oldest byte to the bus. During a read command it fetches one byte from the bus. The request waits while the bus engine is not ready.

Top module: `xfer_fifo_ctrl`

## Requirements
- R1: After reset the fill level is 0, both error outputs and both bus strobes are low, and `host_rdata` is 0. The fill level never exceeds the depth of 8.
- R2: `high_water` is 1 when the fill level is greater than or equal to `hi_mark`. `low_water` is 1 when the fill level is less than or equal to `lo_mark`. Both follow the current level and marks combinationally.
- R3: During a read command (`cmd_active`=1, `cmd_is_read`=1), `data_req` is 1 when `high_water` is set and the FIFO holds at least one byte, or when `front_resid` is 0. Otherwise it is 0.
- R4: During a write command (`cmd_active`=1, `cmd_is_read`=0), `data_req` is 1 when the free space (8 minus the fill level) is at least `back_resid`, or when `low_water` is set. Otherwise it is 0.
- R5: While `cmd_active` is 0, `data_req` is 0.
- R6: A host write (`host_wr`) made while no command is active or while a read command is active raises `err_invalid` for the following cycle and stores nothing.
- R7: A host read (`host_rd`) made while no command is active or while a write command is active raises `err_invalid` for the following cycle and removes nothing.
- R8: A host write to a full FIFO, or a host read from an empty one, moves no data. It raises `err_overrun` for the following cycle when `pacing_en` is 0, and raises no error when `pacing_en` is 1.
- R9: During a write command, each accepted host write or `cmd_start` pulse leaves one pending service. While it is pending, `bus_ready` is 1 and the FIFO is not empty, `bus_tx_valid` is 1 for one cycle with the oldest byte on `bus_tx_data`, and that byte leaves the FIFO. Bytes reach the bus in the order they were written.
- R10: During a read command, each accepted host read or `cmd_start` pulse leaves one pending service. While it is pending, `bus_ready` is 1 and the FIFO is not full, `bus_rx_req` is 1 for one cycle and `bus_rx_data` is stored at the next clock edge.
- R11: An accepted host read loads the oldest byte into `host_rdata` at the next clock edge, in bus arrival order. When a host read and a bus fetch happen in the same cycle, the fill level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_active | input | 1 | A bus command is in progress |
| cmd_is_read | input | 1 | The active command is a read (1) or a write (0) |
| cmd_start | input | 1 | Pulse at command start; requests one bus service |
| pacing_en | input | 1 | Suppresses the overrun error on full writes and empty reads |
| hi_mark | input | 4 | High watermark |
| lo_mark | input | 4 | Low watermark |
| front_resid | input | 16 | Bytes still to move on the bus side |
| back_resid | input | 16 | Bytes still to move on the host side |
| host_wr | input | 1 | Host writes one byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host reads one byte |
| host_rdata | output | 8 | Last byte read by the host |
| bus_ready | input | 1 | Bus engine can take or give a byte this cycle |
| bus_tx_valid | output | 1 | A byte is handed to the bus engine |
| bus_tx_data | output | 8 | Byte handed to the bus engine |
| bus_rx_req | output | 1 | A byte is taken from the bus engine |
| bus_rx_data | input | 8 | Byte from the bus engine |
| fill_level | output | 4 | Bytes currently held |
| high_water | output | 1 | Fill level at or above the high mark |
| low_water | output | 1 | Fill level at or below the low mark |
| data_req | output | 1 | Host should move more data |
| err_invalid | output | 1 | Previous cycle held an access in the wrong direction or with no command |
| err_overrun | output | 1 | Previous cycle held a write to a full FIFO or a read from an empty one without pacing |

## Verification
The hardest state to reach is a full FIFO during a write command. With the bus ready, every accepted write is drained on the next cycle, so the level never rises above one. The stimulus holds `bus_ready` low through eight writes, probes the watermark and write-side data-request rules at an intermediate level, and then tries a ninth write with and without pacing. On the read side, a host read and a bus fetch in the same cycle need two pending services. A two-cycle `cmd_start` pulse builds a level of two bytes, and then back-to-back reads overlap a pop with the fetch left pending by the first read.

// File: rtl/xfer_fifo_pkg.sv
`timescale 1ns/1ps
package xfer_fifo_pkg;
  localparam int FIFO_DEPTH = 8;
  localparam int BYTE_W     = 8;
  localparam int MARK_W     = 4;
  localparam int RESID_W    = 16;

  // Decoded host access for one cycle
  typedef struct packed {
    logic take_wr;   // host write accepted into the FIFO
    logic take_rd;   // host read accepted from the FIFO
    logic bad_dir;   // access with no command or in the wrong direction
    logic overrun;   // full write / empty read without pacing
  } host_dec_t;
endpackage

// File: rtl/xfer_fifo_store.sv
`timescale 1ns/1ps
module xfer_fifo_store #(
  parameter  int DEPTH = 8,
  parameter  int DW    = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count
);
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [DW-1:0]    mem_q [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    unique case ({push, pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage carries no reset; written only under the push enable
  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= push_data;
  end

  assign head  = mem_q[rd_ptr_q];
  assign count = count_q;

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && count_q == CNT_W'(DEPTH)));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && count_q == '0));
endmodule

// File: rtl/xfer_fifo_level.sv
`timescale 1ns/1ps
module xfer_fifo_level #(
  parameter  int CNT_W = 4,
  parameter  int MW    = 4,
  localparam int CMP_W = (CNT_W > MW) ? CNT_W : MW
) (
  input  logic [CNT_W-1:0] count,
  input  logic [MW-1:0]    hi_mark,
  input  logic [MW-1:0]    lo_mark,
  output logic             hi_flag,
  output logic             lo_flag
);
  logic [CMP_W-1:0] cnt_x, hi_x, lo_x;

  always_comb begin
    cnt_x   = CMP_W'(count);
    hi_x    = CMP_W'(hi_mark);
    lo_x    = CMP_W'(lo_mark);
    hi_flag = (cnt_x >= hi_x);
    lo_flag = (cnt_x <= lo_x);
  end
endmodule

// File: rtl/xfer_fifo_ctrl.sv
`timescale 1ns/1ps
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter  int DEPTH = FIFO_DEPTH,
  parameter  int DW    = BYTE_W,
  parameter  int MW    = MARK_W,
  parameter  int RW    = RESID_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_active,
  input  logic             cmd_is_read,
  input  logic             cmd_start,
  input  logic             pacing_en,
  input  logic [MW-1:0]    hi_mark,
  input  logic [MW-1:0]    lo_mark,
  input  logic [RW-1:0]    front_resid,
  input  logic [RW-1:0]    back_resid,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  input  logic             bus_ready,
  output logic             bus_tx_valid,
  output logic [DW-1:0]    bus_tx_data,
  output logic             bus_rx_req,
  input  logic [DW-1:0]    bus_rx_data,
  output logic [CNT_W-1:0] fill_level,
  output logic             high_water,
  output logic             low_water,
  output logic             data_req,
  output logic             err_invalid,
  output logic             err_overrun
);
  host_dec_t        dec;
  logic             wr_mode, rd_mode, is_full, is_empty;
  logic             do_send, do_fetch, svc_done;
  logic             svc_pend_q, svc_pend_d;
  logic             err_inv_q, err_ovr_q;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             push, pop;
  logic [DW-1:0]    push_data, head;
  logic [CNT_W-1:0] count;
  logic [RW-1:0]    free_bytes;

  xfer_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  xfer_fifo_level #(.CNT_W(CNT_W), .MW(MW)) u_level (
    .count   (count),
    .hi_mark (hi_mark),
    .lo_mark (lo_mark),
    .hi_flag (high_water),
    .lo_flag (low_water)
  );

  // host access decode
  always_comb begin
    wr_mode  = cmd_active && !cmd_is_read;
    rd_mode  = cmd_active &&  cmd_is_read;
    is_full  = (count == CNT_W'(DEPTH));
    is_empty = (count == '0);
    dec.take_wr = host_wr && wr_mode && !is_full;
    dec.take_rd = host_rd && rd_mode && !is_empty;
    dec.bad_dir = (host_wr && !wr_mode) || (host_rd && !rd_mode);
    dec.overrun = !pacing_en &&
                  ((host_wr && wr_mode && is_full) ||
                   (host_rd && rd_mode && is_empty));
  end

  // bus-side service: one byte per pending request
  always_comb begin
    do_send  = svc_pend_q && wr_mode && bus_ready && !is_empty;
    do_fetch = svc_pend_q && rd_mode && bus_ready && !is_full;
    svc_done = !cmd_active ||
               (wr_mode && (is_empty || bus_ready)) ||
               (rd_mode && (is_full  || bus_ready));
    svc_pend_d = cmd_start || dec.take_wr || dec.take_rd ||
                 (svc_pend_q && !svc_done);
    push      = dec.take_wr || do_fetch;
    push_data = dec.take_wr ? host_wdata : bus_rx_data;
    pop       = dec.take_rd || do_send;
    rdata_d   = dec.take_rd ? head : rdata_q;
  end

  // data request from watermarks and residuals
  always_comb begin
    free_bytes = RW'(DEPTH) - RW'(count);
    data_req   = 1'b0;
    if (rd_mode)
      data_req = (high_water && !is_empty) || (front_resid == '0);
    else if (wr_mode)
      data_req = (free_bytes >= back_resid) || low_water;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_pend_q <= 1'b0;
      err_inv_q  <= 1'b0;
      err_ovr_q  <= 1'b0;
      rdata_q    <= '0;
    end else begin
      svc_pend_q <= svc_pend_d;
      err_inv_q  <= dec.bad_dir;
      err_ovr_q  <= dec.overrun;
      rdata_q    <= rdata_d;
    end
  end

  assign host_rdata   = rdata_q;
  assign bus_tx_valid = do_send;
  assign bus_tx_data  = head;
  assign bus_rx_req   = do_fetch;
  assign fill_level   = count;
  assign err_invalid  = err_inv_q;
  assign err_overrun  = err_ovr_q;

  // R8
  overrun_pacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> !$past(pacing_en));
  // R6
  invalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_invalid |-> $past(host_wr || host_rd));
  // R10
  fetch_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rx_req && !host_rd) |=> fill_level == $past(fill_level) + 1'b1);
  // R9
  send_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_tx_valid && !host_wr) |=> fill_level == $past(fill_level) - 1'b1);
endmodule

// File: tb/test_xfer_fifo_ctrl.sv
`timescale 1ns/1ps
module test_xfer_fifo_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_active = 0, cmd_is_read = 0, cmd_start = 0, pacing_en = 0;
  logic [3:0]  hi_mark = 0, lo_mark = 0;
  logic [15:0] front_resid = 0, back_resid = 0;
  logic        host_wr = 0, host_rd = 0, bus_ready = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  bus_rx_data = 8'h40;
  logic [7:0]  host_rdata, bus_tx_data;
  logic        bus_tx_valid, bus_rx_req, high_water, low_water, data_req;
  logic        err_invalid, err_overrun;
  logic [3:0]  fill_level;

  xfer_fifo_ctrl i_xfer_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_active(cmd_active), .cmd_is_read(cmd_is_read),
    .cmd_start(cmd_start), .pacing_en(pacing_en), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .front_resid(front_resid), .back_resid(back_resid),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .bus_ready(bus_ready), .bus_tx_valid(bus_tx_valid),
    .bus_tx_data(bus_tx_data), .bus_rx_req(bus_rx_req), .bus_rx_data(bus_rx_data),
    .fill_level(fill_level), .high_water(high_water), .low_water(low_water),
    .data_req(data_req), .err_invalid(err_invalid), .err_overrun(err_overrun));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rd_q[$];
  bit rd_chk = 0, rx_inc = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic host_write(input logic [7:0] b, input bit ok);
    tick(); host_wr = 1'b1; host_wdata = b;
    if (ok) tx_q.push_back(b);
    tick(); host_wr = 1'b0;
  endtask

  task automatic read_burst(input int n);
    tick(); host_rd = 1'b1;
    repeat (n) tick();
    host_rd = 1'b0;
  endtask

  task automatic do_reset();
    tick(); rst_n = 1'b0;
    tx_q.delete(); rd_q.delete(); rd_chk = 0; rx_inc = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  // monitor: compares bus-side and host-side results against the queues
  always begin
    @(negedge clk); #3;
    if (!done && rst_n) begin
      if (rx_inc) begin bus_rx_data = bus_rx_data + 8'd1; rx_inc = 0; end
      if (rd_chk) begin
        rd_chk = 0;
        if (rd_q.size() == 0) check("R11 read without expected byte", 1, 0);
        else check("R11 host_rdata order", host_rdata, rd_q.pop_front());
      end
      if (host_rd && cmd_active && cmd_is_read && fill_level != 0) rd_chk = 1;
      if (bus_rx_req) begin rd_q.push_back(bus_rx_data); rx_inc = 1; end
      if (bus_tx_valid) begin
        if (tx_q.size() == 0) check("R9 unexpected bus send", 1, 0);
        else check("R9 bus_tx_data order", bus_tx_data, tx_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 fill after reset", fill_level, 0);
    check("R1 err_invalid after reset", err_invalid, 0);
    check("R1 err_overrun after reset", err_overrun, 0);
    check("R1 tx strobe after reset", bus_tx_valid, 0);
    check("R1 rx strobe after reset", bus_rx_req, 0);
    check("R1 host_rdata after reset", host_rdata, 0);
    // R5 no command: data_req low even with zero residuals
    check("R5 data_req idle", data_req, 0);
    // R6 write with no command
    host_write(8'h11, 0);
    check("R6 invalid on idle write", err_invalid, 1);
    check("R6 idle write stores nothing", fill_level, 0);
    // R7 read with no command
    read_burst(1);
    check("R7 invalid on idle read", err_invalid, 1);

    // write command, bus stalled so the FIFO accumulates
    tick(); cmd_active = 1; cmd_is_read = 0; bus_ready = 0;
    for (int i = 0; i < 3; i++) host_write(8'hA0 + 8'(i), 1);
    check("R9 stalled bus keeps bytes", fill_level, 3);
    hi_mark = 3; lo_mark = 2; #1;
    check("R2 high_water at mark", high_water, 1);
    check("R2 low_water above mark", low_water, 0);
    hi_mark = 4; lo_mark = 3; #1;
    check("R2 high_water below mark", high_water, 0);
    check("R2 low_water at mark", low_water, 1);
    lo_mark = 1; back_resid = 6; #1;
    check("R4 free 5 < resid 6", data_req, 0);
    back_resid = 5; #1;
    check("R4 free 5 >= resid 5", data_req, 1);
    lo_mark = 3; back_resid = 9; #1;
    check("R4 low_water forces request", data_req, 1);
    // R7 read during write command
    read_burst(1);
    check("R7 invalid on read in write cmd", err_invalid, 1);
    check("R7 read in write cmd moves nothing", fill_level, 3);
    for (int i = 3; i < 8; i++) host_write(8'hA0 + 8'(i), 1);
    check("R8 FIFO full", fill_level, 8);
    // R8 overrun without pacing
    host_write(8'hEE, 0);
    check("R8 overrun on full write", err_overrun, 1);
    check("R8 full write dropped", fill_level, 8);
    tick(); pacing_en = 1;
    host_write(8'hEF, 0);
    check("R8 pacing hides overrun", err_overrun, 0);
    check("R8 paced write not invalid", err_invalid, 0);
    check("R8 paced write dropped", fill_level, 8);
    pacing_en = 0;
    // R9 pending service sends one byte once the bus is ready
    bus_ready = 1;
    tick();
    check("R9 one byte sent", fill_level, 7);
    tick();
    check("R9 one send per access", fill_level, 7);
    host_write(8'hA8, 1);
    check("R9 write lands", fill_level, 8);
    tick();
    check("R9 follow-up send", fill_level, 7);

    // read command
    do_reset();
    cmd_active = 1; cmd_is_read = 1; bus_ready = 1; front_resid = 5; hi_mark = 2;
    read_burst(1);
    check("R8 overrun on empty read", err_overrun, 1);
    check("R8 empty read moves nothing", fill_level, 0);
    host_write(8'h55, 0);
    check("R6 invalid on write in read cmd", err_invalid, 1);
    check("R6 write in read cmd stores nothing", fill_level, 0);
    tick(); cmd_start = 1;
    tick(); tick(); cmd_start = 0;
    tick();
    check("R10 two fetched bytes", fill_level, 2);
    #1;
    check("R3 high_water with data", data_req, 1);
    hi_mark = 3; #1;
    check("R3 below high mark", data_req, 0);
    front_resid = 0; #1;
    check("R3 zero front residual", data_req, 1);
    front_resid = 5; hi_mark = 2;
    read_burst(2);
    check("R11 pop and fetch same cycle keep level", fill_level, 1);
    tick();
    check("R10 fetch after read", fill_level, 2);
    bus_ready = 0;
    read_burst(2);
    check("R11 reads drain FIFO", fill_level, 0);
    tick(); pacing_en = 1;
    read_burst(1);
    check("R8 paced empty read no error", err_overrun, 0);
    check("R8 paced empty read level", fill_level, 0);
    bus_ready = 1;
    tick(); tick();
    check("R10 pending fetch after ready", fill_level, 1);
    cmd_active = 0; front_resid = 0; #1;
    check("R5 data_req after command ends", data_req, 0);
    tick(); tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule